// File: doc/BRIEF.md
# Soft-Ramping Stereo Digital Volume Attenuator

This block scales a stereo stream of signed 24-bit audio samples by a per-channel volume. Each channel holds an 8-bit gain code. Codes 0x00 to 0x7F pick one of 128 pseudo-logarithmic volume steps. Each step maps to a target on a linear scale that runs from 0 (silence) to 8031 (unity). The level that actually scales the audio never jumps. On each sample strobe it moves one count toward its target, so every volume change is heard as a smooth fade.

Two power controls mute the channels. A hardware power-down input clears the level at once and restores the default gain code. On release, the level fades up to unity. A software power bit also clears the level at once but keeps the gain code, so the level fades back to the previous setting. After reset and after either power control is released, the first 516 output samples are forced to zero. An ALC-enable input stands in for an external level-control loop. While it is high, writes of codes 0x80 and above are dropped, and writes in the attenuator range are still accepted.

Top module: `soft_vol_atten`

## Requirements
- R1: Each channel has its own 8-bit gain code. A write with `wr_sel`=0 updates the left channel and `wr_sel`=1 updates the right channel. After reset both codes are 0x7F.
- R2: The target level for each code is computed as follows. Code 0x7F maps to 8031. Each code c from 0x01 to 0x7E maps to floor(level(c+1)*7775/8031). Code 0x00 maps to 0. Codes 0x80 and above map to 8031. The level never exceeds 8031.
- R3: On each `smp_vld` strobe, the level moves exactly one count toward its target, or stays put if it is already there. Without a strobe the level does not change.
- R4: A full ramp between 8031 and 0 takes exactly 8031 strobes, in either direction.
- R5: While `pwr_dn_n` is low, both levels are 0 from the next cycle on. The gain codes return to 0x7F, writes are ignored and `out_vld` stays low. After release, the level ramps from 0 to 8031.
- R6: While `soft_pwr` is low, both levels are 0 from the next cycle on and the gain codes are kept. After it is set again, each level ramps to the target of its kept code.
- R7: After reset, and after `pwr_dn_n` or `soft_pwr` is released, the outputs of the first 516 strobes are zero. The 517th output is not blanked.
- R8: On a strobe, `out_vld` goes high and each output registers a scaled sample one cycle later, using the level held before that strobe. At level 8031 the output equals the input. At any other level L the output is (x*L*8356 + 2^25) >>> 26, computed with signed arithmetic.
- R9: While `alc_en` is high, writes of codes 0x80 to 0xFF are ignored, and writes of codes 0x00 to 0x7F still change the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Hardware power-down, active low |
| soft_pwr | input | 1 | Software power bit, 1 = running |
| alc_en | input | 1 | Level-control loop active |
| wr_en | input | 1 | Gain-code write strobe |
| wr_sel | input | 1 | Write target: 0 left, 1 right |
| wr_code | input | 8 | Gain code to write |
| smp_vld | input | 1 | Sample strobe, one per frame |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| out_vld | output | 1 | Output sample valid |
| out_l | output | 24 | Left scaled sample, signed |
| out_r | output | 24 | Right scaled sample, signed |
| lvl_l | output | 13 | Left current linear level |
| lvl_r | output | 13 | Right current linear level |

## Verification
The assertions assume that every input is synchronous to `clk` and stable across each rising edge, and that `pwr_dn_n` and `soft_pwr` are at defined values from the first clock after reset. The bench drives all inputs on falling edges and holds them for whole cycles. Each write lasts exactly one cycle, and strobes arrive in bursts of consecutive cycles. Ramps are run long enough to settle fully, so every level and blanking count the bench compares is reached exactly.

// File: rtl/svat_pkg.sv
package svat_pkg;

    localparam int CODE_W       = 8;
    localparam int LVL_W        = 13;
    localparam int LVL_MAX      = 8031;
    localparam int STEP_NUM     = 7775;
    localparam int SMP_W        = 24;
    localparam int BLANK_FRAMES = 516;
    localparam int CNT_W        = $clog2(BLANK_FRAMES + 1);
    localparam int SCALE_SH     = 26;
    localparam int SCALE_K      = ((2 ** SCALE_SH) + LVL_MAX / 2) / LVL_MAX;
    localparam logic [CODE_W-1:0] GAIN_RST = 8'h7F;

    // Linear level reached by a code: top code is full scale, each step down
    // multiplies by STEP_NUM/LVL_MAX with truncation, code 0 is silence.
    function automatic int code_level(input int code, input int top_code);
        int v;
        v = LVL_MAX;
        if (code <= 0) return 0;
        for (int i = top_code; i > code; i--) v = (v * STEP_NUM) / LVL_MAX;
        return v;
    endfunction

    typedef struct packed {
        logic [CODE_W-1:0]       gain;
        logic [LVL_W-1:0]        level;
        logic signed [SMP_W-1:0] smp;
    } chan_st_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             vld;
    } blank_st_t;

endpackage

// File: rtl/svat_code_rom.sv
module svat_code_rom #(
    parameter int CODE_W  = svat_pkg::CODE_W,
    parameter int LVL_W   = svat_pkg::LVL_W,
    parameter int LVL_MAX = svat_pkg::LVL_MAX
) (
    input  logic [CODE_W-1:0] code,
    output logic [LVL_W-1:0]  level
);
    localparam int NCODES = 2 ** (CODE_W - 1);

    logic [LVL_W-1:0] tbl [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_tbl
        localparam int ENTRY = svat_pkg::code_level(g, NCODES - 1);
        assign tbl[g] = LVL_W'(ENTRY);
    end

    // Codes with the top bit set lie outside the attenuator range: full scale.
    assign level = code[CODE_W-1] ? LVL_W'(LVL_MAX) : tbl[code[CODE_W-2:0]];

endmodule

// File: rtl/svat_scale.sv
module svat_scale #(
    parameter int SMP_W   = svat_pkg::SMP_W,
    parameter int LVL_W   = svat_pkg::LVL_W,
    parameter int LVL_MAX = svat_pkg::LVL_MAX,
    parameter int SH      = svat_pkg::SCALE_SH,
    parameter int K       = svat_pkg::SCALE_K
) (
    input  logic signed [SMP_W-1:0] smp_in,
    input  logic [LVL_W-1:0]        level,
    output logic signed [SMP_W-1:0] smp_out
);
    localparam int PW = SMP_W + LVL_W + SH;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (SH - 1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;

    always_comb begin
        prod    = $signed(PW'(smp_in)) * $signed(PW'({1'b0, level})) * $signed(PW'(K));
        shifted = (prod + HALF) >>> SH;
        smp_out = (level == LVL_W'(LVL_MAX)) ? smp_in : SMP_W'(shifted);
    end

endmodule

// File: rtl/svat_blank.sv
module svat_blank #(
    parameter int FRAMES = svat_pkg::BLANK_FRAMES,
    parameter int CNT_W  = svat_pkg::CNT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_up,
    input  logic sw_up,
    input  logic smp_vld,
    output logic blank,
    output logic out_vld
);
    import svat_pkg::*;

    blank_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = smp_vld && hw_up;
        if (!hw_up || !sw_up) begin
            st_d.cnt = '0;
        end else if (smp_vld && (st_q.cnt < CNT_W'(FRAMES))) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign blank   = st_q.cnt < CNT_W'(FRAMES);
    assign out_vld = st_q.vld;

    // R7
    blank_cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(FRAMES));

    // R8
    vld_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(smp_vld));

endmodule

// File: rtl/svat_chan.sv
module svat_chan #(
    parameter int CODE_W  = svat_pkg::CODE_W,
    parameter int LVL_W   = svat_pkg::LVL_W,
    parameter int LVL_MAX = svat_pkg::LVL_MAX,
    parameter int SMP_W   = svat_pkg::SMP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hw_up,
    input  logic                    sw_up,
    input  logic                    alc_en,
    input  logic                    wr_en,
    input  logic [CODE_W-1:0]       wr_code,
    input  logic                    smp_vld,
    input  logic                    blank,
    input  logic signed [SMP_W-1:0] smp_in,
    output logic [LVL_W-1:0]        level,
    output logic signed [SMP_W-1:0] smp_out
);
    import svat_pkg::*;

    chan_st_t                st_d, st_q;
    logic [LVL_W-1:0]        code_lvl;
    logic [LVL_W-1:0]        tgt;
    logic signed [SMP_W-1:0] scaled;
    logic                    arm_q;

    svat_code_rom #(.CODE_W(CODE_W), .LVL_W(LVL_W), .LVL_MAX(LVL_MAX)) u_rom (
        .code  (st_q.gain),
        .level (code_lvl)
    );

    svat_scale #(.SMP_W(SMP_W), .LVL_W(LVL_W), .LVL_MAX(LVL_MAX)) u_scale (
        .smp_in  (smp_in),
        .level   (st_q.level),
        .smp_out (scaled)
    );

    always_comb begin
        st_d = st_q;
        tgt  = sw_up ? code_lvl : '0;
        if (!hw_up) begin
            st_d.gain  = GAIN_RST;
            st_d.level = '0;
            st_d.smp   = '0;
        end else begin
            if (wr_en && !(alc_en && wr_code[CODE_W-1])) begin
                st_d.gain = wr_code;
            end
            if (!sw_up) begin
                st_d.level = '0;
            end else if (smp_vld) begin
                if (st_q.level < tgt)      st_d.level = st_q.level + 1'b1;
                else if (st_q.level > tgt) st_d.level = st_q.level - 1'b1;
            end
            if (smp_vld) begin
                st_d.smp = blank ? '0 : scaled;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gain  <= GAIN_RST;
            st_q.level <= '0;
            st_q.smp   <= '0;
            arm_q      <= 1'b0;
        end else begin
            st_q  <= st_d;
            arm_q <= 1'b1;
        end
    end

    assign level   = st_q.level;
    assign smp_out = st_q.smp;

    // R2
    level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.level <= LVL_W'(LVL_MAX));

    // R3
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && $past(hw_up && sw_up)) |->
            ((st_q.level == $past(st_q.level)) ||
             (st_q.level == $past(st_q.level) + 1'b1) ||
             (st_q.level == $past(st_q.level) - 1'b1)));

    // R3
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && $past(hw_up && sw_up && !smp_vld)) |-> (st_q.level == $past(st_q.level)));

    // R5
    hw_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && $past(!hw_up)) |-> (st_q.level == '0 && st_q.gain == GAIN_RST));

    // R6
    sw_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && $past(!sw_up)) |-> (st_q.level == '0));

    // R9
    alc_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && $past(hw_up && alc_en && wr_en && wr_code[CODE_W-1])) |->
            (st_q.gain == $past(st_q.gain)));

    // R7
    blank_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && $past(hw_up && smp_vld && blank)) |-> (st_q.smp == '0));

endmodule

// File: rtl/soft_vol_atten.sv
module soft_vol_atten #(
    parameter int CODE_W = svat_pkg::CODE_W,
    parameter int LVL_W  = svat_pkg::LVL_W,
    parameter int SMP_W  = svat_pkg::SMP_W,
    parameter int NCH    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pwr_dn_n,
    input  logic                    soft_pwr,
    input  logic                    alc_en,
    input  logic                    wr_en,
    input  logic                    wr_sel,
    input  logic [CODE_W-1:0]       wr_code,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] in_l,
    input  logic signed [SMP_W-1:0] in_r,
    output logic                    out_vld,
    output logic signed [SMP_W-1:0] out_l,
    output logic signed [SMP_W-1:0] out_r,
    output logic [LVL_W-1:0]        lvl_l,
    output logic [LVL_W-1:0]        lvl_r
);
    logic signed [SMP_W-1:0] ch_in  [NCH];
    logic signed [SMP_W-1:0] ch_out [NCH];
    logic [LVL_W-1:0]        ch_lvl [NCH];
    logic                    blank;

    assign ch_in[0] = in_l;
    assign ch_in[1] = in_r;

    svat_blank u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_up   (pwr_dn_n),
        .sw_up   (soft_pwr),
        .smp_vld (smp_vld),
        .blank   (blank),
        .out_vld (out_vld)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        svat_chan #(.CODE_W(CODE_W), .LVL_W(LVL_W), .SMP_W(SMP_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .hw_up   (pwr_dn_n),
            .sw_up   (soft_pwr),
            .alc_en  (alc_en),
            .wr_en   (wr_en && (wr_sel == c[0])),
            .wr_code (wr_code),
            .smp_vld (smp_vld),
            .blank   (blank),
            .smp_in  (ch_in[c]),
            .level   (ch_lvl[c]),
            .smp_out (ch_out[c])
        );
    end

    assign out_l = ch_out[0];
    assign out_r = ch_out[1];
    assign lvl_l = ch_lvl[0];
    assign lvl_r = ch_lvl[1];

endmodule

// File: tb/soft_vol_atten_test.sv
module soft_vol_atten_test;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               pwr_dn_n = 1'b1;
    logic               soft_pwr = 1'b1;
    logic               alc_en = 1'b0;
    logic               wr_en = 1'b0;
    logic               wr_sel = 1'b0;
    logic [7:0]         wr_code = 8'h00;
    logic               smp_vld = 1'b0;
    logic signed [23:0] in_l = '0;
    logic signed [23:0] in_r = '0;
    logic               out_vld;
    logic signed [23:0] out_l, out_r;
    logic [12:0]        lvl_l, lvl_r;

    int n_chk = 0;
    int n_bad = 0;

    soft_vol_atten uut (
        .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .soft_pwr(soft_pwr),
        .alc_en(alc_en), .wr_en(wr_en), .wr_sel(wr_sel), .wr_code(wr_code),
        .smp_vld(smp_vld), .in_l(in_l), .in_r(in_r), .out_vld(out_vld),
        .out_l(out_l), .out_r(out_r), .lvl_l(lvl_l), .lvl_r(lvl_r)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic longint ref_lvl(input int code);
        longint v = 8031;
        if (code >= 8'h80) return 8031;
        if (code == 0) return 0;
        for (int k = 8'h7F; k > code; k--) v = (v * 7775) / 8031;
        return v;
    endfunction

    function automatic longint ref_out(input longint x, input longint l);
        longint p;
        if (l == 8031) return x;
        p = x * l * 8356 + (longint'(1) <<< 25);
        return p >>> 26;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            smp_vld = 1'b1;
            @(negedge clk);
        end
        smp_vld = 1'b0;
    endtask

    task automatic write(input logic sel, input logic [7:0] code);
        wr_en = 1'b1; wr_sel = sel; wr_code = code;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset_blank;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "reset level left", lvl_l, 0);
        check("R8", "reset out_vld", out_vld, 0);
        rst_n = 1'b1;
        @(negedge clk);
        in_l = 24'sh400000; in_r = -24'sh400000;
        strobe(516);
        check("R7", "516th output blanked", out_l, 0);
        check("R8", "out_vld after strobe", out_vld, 1);
        check("R3", "level after 516 strobes", lvl_l, 516);
        strobe(1);
        check("R7", "517th output live left", out_l, ref_out(24'sh400000, 516));
        check("R8", "517th output live right", out_r, ref_out(-24'sh400000, 516));
        strobe(8031 - 517);
        check("R1", "default code ramps to full left", lvl_l, 8031);
        check("R4", "default code ramps to full right", lvl_r, 8031);
        @(negedge clk);
        check("R8", "out_vld drops without strobe", out_vld, 0);
    endtask

    task automatic t_unity;
        in_l = 24'sh123456; in_r = -24'sh0ABCDE;
        strobe(1);
        check("R8", "unity left", out_l, 24'sh123456);
        check("R8", "unity right", out_r, -24'sh0ABCDE);
    endtask

    task automatic t_step;
        write(1'b0, 8'h7E);
        strobe(1);
        check("R3", "one count per strobe", lvl_l, 8030);
        check("R1", "right unaffected by left write", lvl_r, 8031);
        strobe(255);
        check("R2", "code 0x7E level", lvl_l, 7775);
        strobe(5);
        check("R3", "level holds at target", lvl_l, 7775);
        in_l = -24'sd1000000;
        strobe(1);
        check("R8", "scaled negative sample", out_l, ref_out(-1000000, 7775));
    endtask

    task automatic t_hold;
        write(1'b0, 8'h7F);
        repeat (10) @(negedge clk);
        check("R3", "no strobe no change", lvl_l, 7775);
        strobe(256);
        check("R3", "ramp back up", lvl_l, 8031);
    endtask

    task automatic t_map;
        write(1'b0, 8'h40);
        write(1'b1, 8'h01);
        strobe(8031);
        check("R2", "code 0x40 level", lvl_l, ref_lvl(8'h40));
        check("R2", "code 0x01 level", lvl_r, ref_lvl(8'h01));
    endtask

    task automatic t_alc;
        alc_en = 1'b1;
        write(1'b0, 8'h90);
        strobe(300);
        check("R9", "high write filtered under ALC", lvl_l, ref_lvl(8'h40));
        write(1'b0, 8'h20);
        strobe(8031);
        check("R9", "low write accepted under ALC", lvl_l, ref_lvl(8'h20));
        alc_en = 1'b0;
        write(1'b0, 8'h90);
        strobe(8031);
        check("R2", "high code maps to full", lvl_l, 8031);
    endtask

    task automatic t_mute;
        write(1'b0, 8'h00);
        strobe(8030);
        check("R4", "one count left before mute", lvl_l, 1);
        strobe(1);
        check("R4", "mute after 8031 strobes", lvl_l, 0);
        write(1'b0, 8'h7F);
        write(1'b1, 8'h7F);
        strobe(8031);
        check("R4", "full scale after 8031 strobes", lvl_l, 8031);
    endtask

    task automatic t_soft;
        write(1'b0, 8'h50);
        strobe(8031);
        soft_pwr = 1'b0;
        @(negedge clk);
        check("R6", "soft off mutes left", lvl_l, 0);
        check("R6", "soft off mutes right", lvl_r, 0);
        strobe(3);
        check("R6", "soft off output zero", out_l, 0);
        soft_pwr = 1'b1;
        in_l = 24'sh400000;
        strobe(516);
        check("R7", "blank after soft on", out_l, 0);
        strobe(1);
        check("R7", "live after soft blank", out_l, ref_out(24'sh400000, 516));
        strobe(8031);
        check("R6", "fade back to kept code", lvl_l, ref_lvl(8'h50));
        check("R6", "right fades back to full", lvl_r, 8031);
    endtask

    task automatic t_hwpd;
        pwr_dn_n = 1'b0;
        @(negedge clk);
        check("R5", "hw down mutes", lvl_l, 0);
        write(1'b0, 8'h10);
        strobe(2);
        check("R5", "no out_vld while down", out_vld, 0);
        pwr_dn_n = 1'b1;
        strobe(8031);
        check("R5", "fade to default after hw up", lvl_l, 8031);
        check("R5", "right fade to default", lvl_r, 8031);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_blank();
        t_unity();
        t_step();
        t_hold();
        t_map();
        t_alc();
        t_mute();
        t_soft();
        t_hwpd();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule